// File: doc/BRIEF.md
# DRAM Page-Mode Access Sequencer

This block turns a stream of read and write requests into the RAS, CAS, multiplexed address and write-strobe sequence for a DRAM behind a 16-bit data bus. Each request carries a word address, a write flag and a flag that marks a single-address DMA transfer. The requester holds a request steady until the block pulses `req_ack` in the column state that moves its data. It then presents its next request, or drops `req_valid`, from the following cycle on.

An access from a closed page takes three states: a precharge state with RAS high and the row address on the pins, a row state that drives RAS low, and a column state that drives CAS low with the column address. When burst operation is enabled and all four wait-select bits are zero, the block runs in short-pitch page mode. In that mode it keeps RAS low while later requests hit the open row, and it serves each of them with a one-state column cycle. A same-row write first gets one silent state, in which RAS stays low, CAS stays high and nothing is transferred. A DMA single-address write gets a silent state even on the first column after the row state. A row miss, or a cycle with no request, closes the page.

Top module: `dram_page_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it with no request, `ras_n`, `cas_n` and `wr_n` are 1 and `req_ack` is 0.
- R2: A request that meets a closed page is acknowledged in its third cycle. Cycle 1 has `ras_n`=1 and the row field on `dram_addr`, cycle 2 has `ras_n`=0, and cycle 3 has `cas_n`=0. Once RAS falls it stays low in the next cycle.
- R3: When `burst_en`=0 or any bit of `wait_sel` is 1, every access takes the full three-state sequence and `req_ack` never stays high for two cycles in a row.
- R4: In page mode (`burst_en`=1, `wait_sel`=0), a read that hits the open row is acknowledged in the cycle it is presented. `ras_n` stays 0, and CAS is only ever low while RAS is low.
- R5: In page mode, a write that hits the open row after a read or a write is acknowledged in its second cycle. Its first cycle is silent (`ras_n`=0, `cas_n`=1, no ack). A write column never directly follows another column cycle.
- R6: In page mode, a read that hits the open row right after a write needs no silent state and is acknowledged in its first cycle.
- R7: A write with `req_dma`=1 always gets a silent state just before its column cycle. That gives two cycles on a page hit and four cycles from a closed page.
- R8: A request whose row field differs from the open row drives `ras_n`=1 with its own row on `dram_addr` in its first cycle, then follows the R2 sequence, for three cycles in all (four for a DMA write).
- R9: A cycle with `req_valid`=0 drives `ras_n`=1 and closes the page, so the next request follows R2.
- R10: The row is `req_addr[ADDR_W-1:COL_W]`, and the column is `req_addr[COL_W-1:0]`, zero-extended onto `dram_addr` in the column cycle. `wr_n` is 0 only in the column cycle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dma | input | 1 | Request is a DMA single-address transfer |
| req_addr | input | ADDR_W | Word address: row field above column field |
| burst_en | input | 1 | Enables page-mode bursts |
| wait_sel | input | 4 | Wait-select bits; page mode only when all are 0 |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| dram_addr | output | ADDR_W-COL_W | Multiplexed row/column address |
| req_ack | output | 1 | Column cycle done; data transferred |

## Verification
The assertions take for granted that a request stays stable from its first cycle until its acknowledge, and that `burst_en` and `wait_sel` change only in cycles with `req_valid` low. The R3 check and the page-hit decode depend on both. The bench drives each request at a falling edge and holds it until the acknowledge is seen. It changes the mode inputs only inside idle gaps. Random rows are drawn from a small set, so page hits, misses and both write orderings all occur often.

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
  parameter int ADDR_W = 20,
  parameter int COL_W  = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_dma,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    burst_en,
  input  logic [3:0]              wait_sel,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic                    wr_n,
  output logic [ADDR_W-COL_W-1:0] dram_addr,
  output logic                    req_ack
);
  localparam int ROW_W = ADDR_W - COL_W;

  typedef enum logic [1:0] {S_IDLE, S_ROW, S_OPEN} st_t;
  st_t st;
  logic [ROW_W-1:0] open_row;
  logic first, silenced;

  logic [ROW_W-1:0] row_in;
  logic [COL_W-1:0] col_in;
  logic page_mode, hit, keep, need_sil, col_cyc, sil_cyc, in_open;

  assign row_in    = req_addr[ADDR_W-1:COL_W];
  assign col_in    = req_addr[COL_W-1:0];
  assign page_mode = burst_en && (wait_sel == 4'd0);
  assign hit       = page_mode && (row_in == open_row);
  assign in_open   = (st == S_OPEN);
  assign keep      = in_open && req_valid && (first || hit);
  assign need_sil  = req_write && (req_dma || !first) && !silenced;
  assign col_cyc   = keep && !need_sil;
  assign sil_cyc   = keep && need_sil;

  assign ras_n     = !((st == S_ROW) || keep);
  assign cas_n     = !col_cyc;
  assign wr_n      = !(col_cyc && req_write);
  assign req_ack   = col_cyc;
  assign dram_addr = keep ? ROW_W'(col_in) : row_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      open_row <= '0;
      first    <= 1'b0;
      silenced <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) st <= S_ROW;
        S_ROW: begin
          open_row <= row_in;
          first    <= 1'b1;
          silenced <= 1'b0;
          st       <= S_OPEN;
        end
        default: begin
          if (col_cyc) begin
            first    <= 1'b0;
            silenced <= 1'b0;
          end else if (sil_cyc) begin
            silenced <= 1'b1;
          end else begin
            first <= 1'b0;
            st    <= req_valid ? S_ROW : S_IDLE;
          end
        end
      endcase
    end
  end

  assert_cas_in_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_ras_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |=> !ras_n);
  assert_no_back_to_back_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && req_write) |-> !$past(req_ack));
  assert_full_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && !(burst_en && wait_sel == 4'd0)) |=> !req_ack);
  assert_dma_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && req_write && req_dma) |-> ($past(!ras_n) && $past(cas_n)));
  assert_wr_in_column_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> req_ack);
endmodule

// File: tb/sim_dram_page_seq.sv
`timescale 1ns/1ps
module sim_dram_page_seq;
  logic clk = 1'b0;
  logic rst_n, req_valid, req_write, req_dma, burst_en;
  logic [19:0] req_addr;
  logic [3:0] wait_sel;
  logic ras_n, cas_n, wr_n, req_ack;
  logic [10:0] dram_addr;

  int total = 0, bad = 0;
  bit finished = 0;
  bit page_open = 0;
  bit prev_write = 0;
  logic [10:0] m_row = '0;

  always #2.5 clk = ~clk;

  dram_page_seq #(.ADDR_W(20), .COL_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_dma(req_dma), .req_addr(req_addr), .burst_en(burst_en), .wait_sel(wait_sel),
    .ras_n(ras_n), .cas_n(cas_n), .wr_n(wr_n), .dram_addr(dram_addr), .req_ack(req_ack));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit hit_open, input bit w, input bit d);
    if (hit_open) return w ? 2 : 1;
    return (w && d) ? 4 : 3;
  endfunction

  function automatic bit pmode();
    return burst_en && (wait_sel == 4'd0);
  endfunction

  task automatic do_req(input logic [19:0] a, input bit w, input bit d);
    logic [10:0] row;
    bit hit_open, sil, done;
    int exp, n;
    string tag;
    row = a[19:9];
    hit_open = page_open && (row == m_row);
    exp = exp_lat(hit_open, w, d);
    sil = w && (hit_open || d);
    if (!pmode()) tag = "R3";
    else if (w && d) tag = "R7";
    else if (hit_open && w) tag = "R5";
    else if (hit_open && prev_write) tag = "R6";
    else if (hit_open) tag = "R4";
    else if (page_open) tag = "R8";
    else tag = "R2";
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_dma = d;
    n = 0; done = 0;
    while (!done && n < 20) begin
      #1;
      n++;
      if (n == 1 && !hit_open)
        chk(ras_n == 1'b1 && dram_addr == row, {tag, " precharge row"}, int'(dram_addr), int'(row));
      if (sil && n == exp - 1)
        chk(cas_n && !ras_n && !req_ack, {tag, " silent state"}, int'({ras_n, cas_n}), 1);
      if (req_ack) done = 1;
      else begin
        chk(wr_n == 1'b1, "R10 wr_n idle", int'(wr_n), 1);
        @(negedge clk);
      end
    end
    chk(n == exp, {tag, " latency"}, n, exp);
    chk(dram_addr == {2'b00, a[8:0]}, "R10 column address", int'(dram_addr), int'(a[8:0]));
    chk(wr_n == !w && !cas_n && !ras_n, "R10 strobes", int'({ras_n, cas_n, wr_n}), int'({2'b00, !w}));
    page_open = pmode();
    m_row = row;
    prev_write = w;
  endtask

  task automatic gap();
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    chk(ras_n == 1'b1 && cas_n == 1'b1 && !req_ack, "R9 idle closes page", int'({ras_n, cas_n}), 3);
    page_open = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [19:0] a;
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    rst_n = 0; req_valid = 0; req_write = 0; req_dma = 0; req_addr = '0;
    burst_en = 1; wait_sel = 4'd0;
    repeat (3) @(negedge clk);
    #1 chk(ras_n && cas_n && wr_n && !req_ack, "R1 reset outputs", int'({ras_n, cas_n, wr_n, req_ack}), 14);
    @(negedge clk); rst_n = 1;
    #1 chk(ras_n && cas_n && wr_n && !req_ack, "R1 after reset", int'({ras_n, cas_n, wr_n, req_ack}), 14);

    do_req({11'h05, 9'h010}, 0, 0);
    do_req({11'h05, 9'h011}, 0, 0);
    do_req({11'h05, 9'h012}, 1, 0);
    do_req({11'h05, 9'h013}, 1, 0);
    do_req({11'h05, 9'h014}, 0, 0);
    do_req({11'h05, 9'h1FF}, 1, 1);
    do_req({11'h06, 9'h000}, 0, 0);
    do_req({11'h06, 9'h001}, 0, 1);
    gap();
    do_req({11'h7FF, 9'h0AA}, 1, 1);
    gap();
    burst_en = 0;
    do_req({11'h01, 9'h002}, 0, 0);
    do_req({11'h01, 9'h003}, 1, 0);
    gap();
    burst_en = 1; wait_sel = 4'b0010;
    do_req({11'h01, 9'h004}, 0, 0);
    do_req({11'h01, 9'h005}, 0, 0);
    gap();
    wait_sel = 4'd0;

    for (int i = 0; i < 400; i++) begin
      if ($urandom % 10 == 0) begin
        gap();
        if ($urandom % 4 == 0) begin
          burst_en = $urandom % 2;
          wait_sel = ($urandom % 2) ? 4'd0 : 4'($urandom % 16);
        end else begin
          burst_en = 1; wait_sel = 4'd0;
        end
      end
      a = {11'($urandom % 3), 9'($urandom)};
      do_req(a, 1'($urandom % 2), ($urandom % 5 == 0));
    end
    gap();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule